// File: doc/BRIEF.md
# Quick-Branch Next-PC Unit

This block works out the program counter of the next instruction for a word-addressed core. Each cycle it takes the current PC, the first source register, a second operand and the fields of a branch or jump instruction. The second operand is either an 8-bit immediate, zero-extended, or the second source register, as the immediate-select bit chooses. From these it produces the registered next PC. For jump-and-link it also produces a link value and a write strobe for the destination register.

It handles six unsigned compare branches and an always-taken branch. It also handles two branches that test one bit of the first source register, an absolute jump and a jump-and-link. The compare branches put the second operand on the left: "greater than" means the second operand exceeds the first source register. A taken branch adds the sign-extended offset to the PC. Every other outcome steps the PC by one word. Fetch, flushing and the register file belong to the surrounding core.

Top module: `nxpc_unit`

## Requirements
- R1: While `rst_n` is low, `npc_o`, `link_we_o` and `link_o` read zero.
- R2: All three outputs are registered. Inputs sampled at a rising clock edge appear on the outputs right after that edge and stay until the next one.
- R3: Opcodes 1 to 6 are compare branches, with OP2 the second operand and RS1 the first source register, all compares unsigned. 1 is taken when OP2 > RS1, 2 when OP2 >= RS1, 3 when OP2 < RS1, 4 when OP2 <= RS1, 5 when OP2 == RS1 and 6 when OP2 != RS1.
- R4: A taken branch gives `pc_i` plus `off_i` sign-extended to the PC width. A branch that is not taken gives `pc_i + 1`. Both wrap modulo 2^PC_W.
- R5: Opcode 7 always gives `pc_i` plus the sign-extended offset, whatever the operands hold.
- R6: Opcode 8 is taken when bit `OP2[4:0]` of RS1 is 1, and opcode 9 when that bit is 0. The upper bits of OP2 play no part.
- R7: With `imm_sel_i` = 1, OP2 is `imm_i` zero-extended to 32 bits. With 0, it is `rs2_i`.
- R8: Opcode 10 (jump) gives `jimm_i` when `imm_sel_i` = 1, else `rs2_i[15:0]`. It writes no link.
- R9: Opcode 11 (jump-and-link) takes its target as in R8, sets `link_we_o` = 1 and sets `link_o` to `pc_i + 1`, wrapped to 16 bits and zero-extended.
- R10: Opcode 0 and opcodes 12 to 15 give `pc_i + 1`. For every opcode other than 11, `link_we_o` = 0 and `link_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Branch/jump opcode (codes in R3 to R10) |
| imm_sel_i | input | 1 | 1 selects the immediates, 0 selects `rs2_i` |
| pc_i | input | 16 | Current program counter (word address) |
| rs1_i | input | 32 | First source register |
| rs2_i | input | 32 | Second source register |
| imm_i | input | 8 | Short immediate for the second operand |
| off_i | input | 10 | Signed branch offset in words |
| jimm_i | input | 16 | Absolute jump immediate |
| npc_o | output | 16 | Next program counter |
| link_we_o | output | 1 | Link write strobe for the destination register |
| link_o | output | 32 | Link value (return address) |

## Verification
Every result, whether next PC, link strobe or link value, is due one rising edge after its inputs are presented, and no result takes longer. The bench changes inputs on the falling edge, waits for the next rising edge and samples one time unit later. There it compares all three outputs with values its own model computes from the same inputs. The checker's properties look back exactly one cycle with `$past` and only fire when reset was already released in that cycle.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

    typedef enum logic [3:0] {
        OP_SEQ  = 4'h0,
        OP_BGT  = 4'h1,
        OP_BGE  = 4'h2,
        OP_BLT  = 4'h3,
        OP_BLE  = 4'h4,
        OP_BEQ  = 4'h5,
        OP_BNE  = 4'h6,
        OP_BALW = 4'h7,
        OP_BBS  = 4'h8,
        OP_BBC  = 4'h9,
        OP_JMP  = 4'hA,
        OP_JAL  = 4'hB
    } nxpc_op_e;

    // true for every opcode whose outcome depends on a condition
    function automatic logic is_cond_branch(nxpc_op_e op);
        return (op inside {OP_BGT, OP_BGE, OP_BLT, OP_BLE,
                           OP_BEQ, OP_BNE, OP_BBS, OP_BBC});
    endfunction

    // true for the absolute-target opcodes
    function automatic logic is_abs_jump(nxpc_op_e op);
        return (op == OP_JMP) || (op == OP_JAL);
    endfunction

endpackage

// File: rtl/nxpc_operand_sel.sv
module nxpc_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              imm_sel_i,
    input  logic [DATA_W-1:0] rs2_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] op2_o
);

    logic [DATA_W-1:0] imm_ext;

    generate
        if (IMM_W < DATA_W) begin : g_pad
            assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_i};
        end else begin : g_trunc
            assign imm_ext = imm_i[DATA_W-1:0];
        end
    endgenerate

    assign op2_o = imm_sel_i ? imm_ext : rs2_i;

endmodule

// File: rtl/nxpc_cond_eval.sv
module nxpc_cond_eval
    import nxpc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  nxpc_op_e          op_i,
    input  logic [DATA_W-1:0] rs1_i,
    input  logic [DATA_W-1:0] op2_i,
    output logic              taken_o
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic             op2_gt;
    logic             op2_eq;
    logic [IDX_W-1:0] bit_idx;
    logic             bit_hit;

    // one magnitude compare and one equality feed all six compare forms
    assign op2_gt  = (op2_i > rs1_i);
    assign op2_eq  = (op2_i == rs1_i);
    assign bit_idx = op2_i[IDX_W-1:0];
    assign bit_hit = rs1_i[bit_idx];

    always_comb begin
        unique case (op_i)
            OP_BGT:  taken_o = op2_gt;
            OP_BGE:  taken_o = op2_gt | op2_eq;
            OP_BLT:  taken_o = ~(op2_gt | op2_eq);
            OP_BLE:  taken_o = ~op2_gt;
            OP_BEQ:  taken_o = op2_eq;
            OP_BNE:  taken_o = ~op2_eq;
            OP_BBS:  taken_o = bit_hit;
            OP_BBC:  taken_o = ~bit_hit;
            default: taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/nxpc_target_gen.sv
module nxpc_target_gen #(
    parameter int PC_W   = 16,
    parameter int OFS_W  = 10,
    parameter int JIMM_W = 16
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [OFS_W-1:0]  off_i,
    input  logic              imm_sel_i,
    input  logic [JIMM_W-1:0] jimm_i,
    input  logic [PC_W-1:0]   rs2_lo_i,
    output logic [PC_W-1:0]   pc_seq_o,
    output logic [PC_W-1:0]   pc_br_o,
    output logic [PC_W-1:0]   pc_jmp_o
);

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] jimm_ext;

    generate
        if (OFS_W < PC_W) begin : g_ofs_sext
            assign off_ext = {{(PC_W-OFS_W){off_i[OFS_W-1]}}, off_i};
        end else begin : g_ofs_trunc
            assign off_ext = off_i[PC_W-1:0];
        end

        if (JIMM_W == PC_W) begin : g_jimm_eq
            assign jimm_ext = jimm_i;
        end else if (JIMM_W < PC_W) begin : g_jimm_pad
            assign jimm_ext = {{(PC_W-JIMM_W){1'b0}}, jimm_i};
        end else begin : g_jimm_trunc
            assign jimm_ext = jimm_i[PC_W-1:0];
        end
    endgenerate

    assign pc_seq_o = pc_i + PC_W'(1);
    assign pc_br_o  = pc_i + off_ext;
    assign pc_jmp_o = imm_sel_i ? jimm_ext : rs2_lo_i;

endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int OFS_W  = 10,
    parameter int JIMM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic              imm_sel_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DATA_W-1:0] rs1_i,
    input  logic [DATA_W-1:0] rs2_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [OFS_W-1:0]  off_i,
    input  logic [JIMM_W-1:0] jimm_i,
    output logic [PC_W-1:0]   npc_o,
    output logic              link_we_o,
    output logic [DATA_W-1:0] link_o
);

    typedef struct packed {
        logic [PC_W-1:0]   npc;
        logic              link_we;
        logic [DATA_W-1:0] link;
    } nxpc_state_t;

    nxpc_op_e          op;
    logic [DATA_W-1:0] op2;
    logic              taken;
    logic [PC_W-1:0]   pc_seq;
    logic [PC_W-1:0]   pc_br;
    logic [PC_W-1:0]   pc_jmp;
    logic [DATA_W-1:0] link_val;
    nxpc_state_t       st_d;
    nxpc_state_t       st_q;

    assign op = nxpc_op_e'(op_i);

    nxpc_operand_sel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_opsel (
        .imm_sel_i (imm_sel_i),
        .rs2_i     (rs2_i),
        .imm_i     (imm_i),
        .op2_o     (op2)
    );

    nxpc_cond_eval #(
        .DATA_W (DATA_W)
    ) u_cond (
        .op_i    (op),
        .rs1_i   (rs1_i),
        .op2_i   (op2),
        .taken_o (taken)
    );

    nxpc_target_gen #(
        .PC_W   (PC_W),
        .OFS_W  (OFS_W),
        .JIMM_W (JIMM_W)
    ) u_tgt (
        .pc_i      (pc_i),
        .off_i     (off_i),
        .imm_sel_i (imm_sel_i),
        .jimm_i    (jimm_i),
        .rs2_lo_i  (rs2_i[PC_W-1:0]),
        .pc_seq_o  (pc_seq),
        .pc_br_o   (pc_br),
        .pc_jmp_o  (pc_jmp)
    );

    generate
        if (DATA_W > PC_W) begin : g_link_pad
            assign link_val = {{(DATA_W-PC_W){1'b0}}, pc_seq};
        end else begin : g_link_trunc
            assign link_val = pc_seq[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        st_d         = '0;
        st_d.npc     = pc_seq;
        if (is_cond_branch(op)) begin
            st_d.npc = taken ? pc_br : pc_seq;
        end else if (op == OP_BALW) begin
            st_d.npc = pc_br;
        end else if (is_abs_jump(op)) begin
            st_d.npc = pc_jmp;
            if (op == OP_JAL) begin
                st_d.link_we = 1'b1;
                st_d.link    = link_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign npc_o     = st_q.npc;
    assign link_we_o = st_q.link_we;
    assign link_o    = st_q.link;

endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk #(
    parameter int PC_W   = 16,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 10,
    parameter int JIMM_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic              imm_sel_i,
    input logic [PC_W-1:0]   pc_i,
    input logic [OFS_W-1:0]  off_i,
    input logic [JIMM_W-1:0] jimm_i,
    input logic [PC_W-1:0]   npc_o,
    input logic              link_we_o,
    input logic [DATA_W-1:0] link_o
);

    logic [PC_W-1:0] off_x;
    assign off_x = PC_W'($signed(off_i));

    // R10
    link_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_we_o |-> (link_o == '0));

    // R9
    link_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && link_we_o) |->
            (link_o[PC_W-1:0] == PC_W'($past(pc_i) + PC_W'(1))));

    // R9
    link_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && link_we_o) |-> ($past(op_i) == 4'hB));

    // R5
    always_br_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == 4'h7)) |->
            (npc_o == PC_W'($past(pc_i) + $past(off_x))));

    // R8
    jump_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == 4'hA) && $past(imm_sel_i)) |->
            (npc_o == PC_W'($past(jimm_i)) && !link_we_o));

    // R10
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) >= 4'hC)) |->
            (npc_o == PC_W'($past(pc_i) + PC_W'(1)) && !link_we_o));

endmodule

bind nxpc_unit nxpc_unit_chk #(
    .PC_W   (PC_W),
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W),
    .JIMM_W (JIMM_W)
) u_nxpc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .imm_sel_i (imm_sel_i),
    .pc_i      (pc_i),
    .off_i     (off_i),
    .jimm_i    (jimm_i),
    .npc_o     (npc_o),
    .link_we_o (link_we_o),
    .link_o    (link_o)
);

// File: tb/nxpc_unit_bench.sv
module nxpc_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic        imm_sel_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [31:0] rs1_i = '0;
    logic [31:0] rs2_i = '0;
    logic [7:0]  imm_i = '0;
    logic [9:0]  off_i = '0;
    logic [15:0] jimm_i = '0;
    logic [15:0] npc_o;
    logic        link_we_o;
    logic [31:0] link_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nxpc_unit u_nxpc_unit (
        .clk (clk), .rst_n (rst_n), .op_i (op_i), .imm_sel_i (imm_sel_i),
        .pc_i (pc_i), .rs1_i (rs1_i), .rs2_i (rs2_i), .imm_i (imm_i),
        .off_i (off_i), .jimm_i (jimm_i), .npc_o (npc_o),
        .link_we_o (link_we_o), .link_o (link_o)
    );

    function automatic logic [31:0] f_op2(logic sel, logic [7:0] im, logic [31:0] r2);
        return sel ? {24'd0, im} : r2;
    endfunction

    function automatic logic f_taken(logic [3:0] op, logic [31:0] a, logic [31:0] b);
        // a = RS1, b = OP2
        case (op)
            4'h1: return b > a;
            4'h2: return b >= a;
            4'h3: return b < a;
            4'h4: return b <= a;
            4'h5: return b == a;
            4'h6: return b != a;
            4'h7: return 1'b1;
            4'h8: return a[b[4:0]];
            4'h9: return !a[b[4:0]];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] f_npc(logic [3:0] op, logic sel, logic [15:0] pc,
                                          logic [31:0] r1, logic [31:0] r2, logic [7:0] im,
                                          logic [9:0] off, logic [15:0] ji);
        logic [15:0] step;
        logic [15:0] br;
        step = pc + 16'd1;
        br   = pc + {{6{off[9]}}, off};
        if (op == 4'hA || op == 4'hB) return sel ? ji : r2[15:0];
        if (op >= 4'h1 && op <= 4'h9)
            return f_taken(op, r1, f_op2(sel, im, r2)) ? br : step;
        return step;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(string req, logic [3:0] op, logic sel, logic [15:0] pc,
                         logic [31:0] r1, logic [31:0] r2, logic [7:0] im,
                         logic [9:0] off, logic [15:0] ji);
        logic [15:0] e_npc;
        logic        e_we;
        logic [31:0] e_link;
        @(negedge clk);
        op_i = op; imm_sel_i = sel; pc_i = pc; rs1_i = r1; rs2_i = r2;
        imm_i = im; off_i = off; jimm_i = ji;
        e_npc  = f_npc(op, sel, pc, r1, r2, im, off, ji);
        e_we   = (op == 4'hB);
        e_link = e_we ? {16'd0, pc + 16'd1} : 32'd0;
        @(posedge clk);
        #1;
        check(req, "npc", {16'd0, npc_o}, {16'd0, e_npc});
        check(req, "link_we", {31'd0, link_we_o}, {31'd0, e_we});
        check(req, "link", link_o, e_link);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: outputs zero while reset held, even with JAL presented
        op_i = 4'hB; imm_sel_i = 1'b1; pc_i = 16'h1234; jimm_i = 16'hBEEF;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "npc", {16'd0, npc_o}, 32'd0);
        check("R1", "link_we", {31'd0, link_we_o}, 32'd0);
        check("R1", "link", link_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: equality boundary, register operand (R7 sel=0)
        apply("R3", 4'h1, 1'b0, 16'h0100, 32'h55, 32'h55, 8'h00, 10'h010, 16'h0);
        apply("R3", 4'h2, 1'b0, 16'h0100, 32'h55, 32'h55, 8'h00, 10'h010, 16'h0);
        apply("R3", 4'h3, 1'b0, 16'h0100, 32'h55, 32'h55, 8'h00, 10'h010, 16'h0);
        apply("R3", 4'h4, 1'b0, 16'h0100, 32'h55, 32'h55, 8'h00, 10'h010, 16'h0);
        apply("R3", 4'h5, 1'b0, 16'h0100, 32'h55, 32'h55, 8'h00, 10'h010, 16'h0);
        apply("R3", 4'h6, 1'b0, 16'h0100, 32'h55, 32'h55, 8'h00, 10'h010, 16'h0);
        // R3: operand order and unsigned compare (OP2 huge, RS1 small)
        apply("R3", 4'h1, 1'b0, 16'h0200, 32'h1, 32'h8000_0000, 8'h0, 10'h020, 16'h0);
        apply("R3", 4'h3, 1'b0, 16'h0200, 32'h1, 32'h8000_0000, 8'h0, 10'h020, 16'h0);
        // R7: immediate zero-extended, rs2 ignored
        apply("R7", 4'h5, 1'b1, 16'h0300, 32'h0000_00F0, 32'hFFFF_FFF0, 8'hF0, 10'h005, 16'h0);
        apply("R7", 4'h1, 1'b1, 16'h0300, 32'hFFFF_FFF0, 32'h0, 8'hFF, 10'h005, 16'h0);
        // R4: negative offset and wrap
        apply("R4", 4'h5, 1'b0, 16'h0005, 32'h7, 32'h7, 8'h0, 10'h3F0, 16'h0);
        apply("R4", 4'h6, 1'b0, 16'hFFFF, 32'h7, 32'h7, 8'h0, 10'h3F0, 16'h0);
        // R5: always-branch regardless of operands, max negative offset
        apply("R5", 4'h7, 1'b0, 16'h0100, 32'h0, 32'hFFFF_FFFF, 8'h0, 10'h200, 16'h0);
        apply("R5", 4'h7, 1'b1, 16'hFFF0, 32'h1, 32'h2, 8'h3, 10'h1FF, 16'h0);
        // R6: bit index from low five bits; upper bits of OP2 ignored
        apply("R6", 4'h8, 1'b0, 16'h0400, 32'h8000_0000, 32'hFFFF_FFFF, 8'h0, 10'h040, 16'h0);
        apply("R6", 4'h9, 1'b0, 16'h0400, 32'h8000_0000, 32'hFFFF_FFFF, 8'h0, 10'h040, 16'h0);
        apply("R6", 4'h8, 1'b1, 16'h0400, 32'h0000_0001, 32'h0, 8'hE0, 10'h040, 16'h0);
        apply("R6", 4'h9, 1'b1, 16'h0400, 32'hFFFF_FFFE, 32'h0, 8'h20, 10'h040, 16'h0);
        // R8: jump by immediate and by register
        apply("R8", 4'hA, 1'b1, 16'h0500, 32'h0, 32'h0001_2345, 8'h0, 10'h0, 16'hCAFE);
        apply("R8", 4'hA, 1'b0, 16'h0500, 32'h0, 32'hABCD_2345, 8'h0, 10'h0, 16'hCAFE);
        // R9: jump-and-link, including wrap of link value
        apply("R9", 4'hB, 1'b1, 16'h0600, 32'h0, 32'h0, 8'h0, 10'h0, 16'h0042);
        apply("R9", 4'hB, 1'b0, 16'hFFFF, 32'h0, 32'h0000_1111, 8'h0, 10'h0, 16'h0042);
        // R10: undefined opcodes step and clear link
        apply("R10", 4'h0, 1'b1, 16'h0700, 32'h1, 32'h1, 8'h1, 10'h100, 16'h9999);
        apply("R10", 4'hF, 1'b1, 16'hFFFF, 32'h1, 32'h1, 8'h1, 10'h100, 16'h9999);

        // R2: random mix; each result checked one edge after presentation
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  op;
            logic [31:0] r1;
            logic [31:0] r2;
            logic [7:0]  im;
            op = 4'($urandom % 16);
            r1 = $urandom;
            r2 = ($urandom % 4 == 0) ? r1 : $urandom;
            im = ($urandom % 4 == 0) ? r1[7:0] : 8'($urandom);
            if ($urandom % 4 == 0) r1 = {24'd0, r1[7:0]};
            apply("R2", op, 1'($urandom), 16'($urandom), r1, r2, im,
                  10'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule